// File: doc/BRIEF.md
# Clock-Domain Timer Register Bridge

This block is an 8-bit free-running timer that counts on a slow timer clock unrelated to the system clock. It is programmed over a simple system-clock bus. The bus can write five registers: the count, two compare values and two control words. Each write is captured in its own staging register on the system side. A toggle handshake then carries it into the timer clock domain, and an acknowledge toggle returns to retire it. While a register's transfer is in flight, its busy bit is set. Further writes to that register are dropped, not queued.

Reads of the count return a system-side copy, which is refreshed once per timer clock edge. Compare-match and overflow events in the timer domain travel back as toggles and set sticky flags that software clears by writing ones. Compare detection is blanked while a write to the count or to either compare register is pending. A wake request pulse, gated per event by a mask in the second control word, is driven in the timer domain one timer cycle after the event.

Address map: 0 count, 1 compare A, 2 compare B, 3 control 0 (bit 0 = run), 4 control 1 (bits 2:0 = wake mask per flag), 5 busy status, 6 flags. Flag bits: 0 compare A, 1 compare B, 2 overflow.

Top module: `tmr_async_bridge`

## Requirements
- R1: After reset, every bus address reads 0, `irq_flags` is 0 and `wake_req` is low.
- R2: A write to address n (0 to 4) whose busy bit is clear stores the value and sets status bit n from the next system cycle. The bit stays set for two to three timer periods plus three system cycles.
- R3: A write to a register whose busy bit is set is ignored: the stored value is kept, and the busy bit clears once and does not set again.
- R4: Pending writes to different registers proceed independently, and all of them land.
- R5: In the system cycle when the count's busy bit clears, a read of address 0 returns the written count value.
- R6: The count read-back changes at most once per timer period. While control 0 bit 0 is set, it steps by +1 each timer period. While that bit is clear, it holds.
- R7: Flag bit 2 (overflow) sets in the same system cycle in which the count read-back first shows 0 after 255.
- R8: Flag bit 0 (or bit 1) sets in the same system cycle in which the count read-back first shows compare A (or B) plus one.
- R9: Writing a one to a bit of `flag_clr` clears only that flag bit. The other flags are unchanged.
- R10: No compare flag is raised for a count value that is matched while a write to the count or to a compare register is pending.
- R11: `wake_req` pulses high for exactly one timer period after an event whose mask bit in control 1 is set. A masked-off event produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | System-domain reset, asynchronous, active high |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Timer-domain reset, asynchronous, active high |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| irq_flags | output | 3 | Sticky event flags |
| wake_req | output | 1 | Timer-domain wake pulse |

## Verification
A wrong handshake state shows up at the status address. A busy bit that sticks, never sets, or sets again after an ignored write is visible within about three timer periods of the write. A stale or skipped read-back copy, or a flag path that is too long or too short, breaks the fixed relation between the flag edge and the count value in the same system cycle. That relation is checked on the first event after the stimulus. A broken blanking window raises a compare flag a few timer periods after the count write, long before the count comes round to the compare value again.

// File: rtl/tmr_bridge_pkg.sv
package tmr_bridge_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int REG_N  = 5;
    localparam int FLAG_N = 3;

    localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL0 = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;

    localparam int F_CMPA = 0;
    localparam int F_CMPB = 1;
    localparam int F_OVF  = 2;
    localparam int RUN_BIT = 0;
endpackage

// File: rtl/tmr_xfer_chan.sv
// One staged register: system-side staging plus busy, toggle request into the
// timer domain, toggle acknowledge back.
module tmr_xfer_chan #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_val,
    output logic         busy,
    output logic [W-1:0] stage_val,
    input  logic         tmr_clk,
    input  logic         tmr_rst,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val
);
    typedef struct packed {
        logic [W-1:0] stage;
        logic         busy;
        logic         req;
        logic         ack_m;
        logic         ack_s;
    } sys_st_t;

    typedef struct packed {
        logic [W-1:0] dest;
        logic         req_m;
        logic         req_s;
        logic         req_p;
        logic         ack;
    } tmr_st_t;

    sys_st_t s_d, s_q;
    tmr_st_t t_d, t_q;

    // system side
    always_comb begin
        s_d       = s_q;
        s_d.ack_m = t_q.ack;
        s_d.ack_s = s_q.ack_m;
        if (s_q.busy && (s_q.ack_s == s_q.req)) begin
            s_d.busy = 1'b0;
        end
        if (wr_stb && !s_q.busy) begin
            s_d.stage = wr_val;
            s_d.busy  = 1'b1;
            s_d.req   = ~s_q.req;
        end
    end

    always_ff @(posedge sys_clk or posedge sys_rst) begin
        if (sys_rst) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign stage_val = s_q.stage;

    // timer side: the staged value is stable while busy, so it is sampled directly
    assign tmr_load = t_q.req_s ^ t_q.req_p;

    always_comb begin
        t_d       = t_q;
        t_d.req_m = s_q.req;
        t_d.req_s = t_q.req_m;
        t_d.req_p = t_q.req_s;
        if (tmr_load) begin
            t_d.dest = s_q.stage;
            t_d.ack  = t_q.req_s;
        end
    end

    always_ff @(posedge tmr_clk or posedge tmr_rst) begin
        if (tmr_rst) t_q <= '0;
        else         t_q <= t_d;
    end

    assign tmr_val = t_q.dest;

    assert_busy_from_write_R2: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(s_q.busy) |-> $past(wr_stb));

    assert_busy_write_dropped_R3: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (s_q.busy && wr_stb) |=> ($stable(s_q.stage) && $stable(s_q.req)));

    assert_single_load_R4: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        tmr_load |=> !tmr_load);
endmodule

// File: rtl/tmr_flag_sync.sv
// Event toggles from the timer domain become sticky write-one-to-clear flags.
module tmr_flag_sync #(
    parameter int N = 3
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic [N-1:0] tog_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] m;
        logic [N-1:0] s;
        logic [N-1:0] p;
        logic [N-1:0] flag;
    } st_t;

    st_t d, q;
    logic [N-1:0] seen;

    assign seen = q.s ^ q.p;

    always_comb begin
        d      = q;
        d.m    = tog_in;
        d.s    = q.m;
        d.p    = q.s;
        d.flag = (q.flag & ~clr) | seen;
    end

    always_ff @(posedge sys_clk or posedge sys_rst) begin
        if (sys_rst) q <= '0;
        else         q <= d;
    end

    assign flags = q.flag;

    assert_w1c_clears_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (|(clr & ~seen)) |=> ((q.flag & $past(clr & ~seen)) == '0));

    assert_flag_needs_event_R7: assert property (@(posedge sys_clk) disable iff (sys_rst)
        ((q.flag & ~$past(q.flag) & ~$past(seen)) == '0));
endmodule

// File: rtl/tmr_count_core.sv
// Timer-domain counter, compare with write blanking, event toggles, wake pulse.
module tmr_count_core
    import tmr_bridge_pkg::*;
#(
    parameter int W  = 8,
    parameter int NF = 3
) (
    input  logic          tmr_clk,
    input  logic          tmr_rst,
    input  logic          cnt_load,
    input  logic [W-1:0]  cnt_val,
    input  logic [W-1:0]  cmp_a,
    input  logic [W-1:0]  cmp_b,
    input  logic          run,
    input  logic [NF-1:0] wake_mask,
    input  logic          blank_src,
    output logic [NF-1:0] evt_tog,
    output logic          tick,
    output logic [W-1:0]  count,
    output logic          wake_req
);
    localparam logic [W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [W-1:0]  count;
        logic          blank_m;
        logic          blank_q;
        logic          tick;
        logic [NF-1:0] tog;
        logic          wake;
    } st_t;

    st_t d, q;
    logic [NF-1:0] ev;

    always_comb begin
        ev         = '0;
        ev[F_CMPA] = run && !q.blank_q && (q.count == cmp_a);
        ev[F_CMPB] = run && !q.blank_q && (q.count == cmp_b);
        ev[F_OVF]  = run && (q.count == CNT_TOP);

        d         = q;
        d.blank_m = blank_src;
        d.blank_q = q.blank_m;
        d.tick    = ~q.tick;
        d.tog     = q.tog ^ ev;
        d.wake    = |(ev & wake_mask);
        if (cnt_load) begin
            d.count = cnt_val;
        end else if (run) begin
            d.count = q.count + 1'b1;
        end
    end

    always_ff @(posedge tmr_clk or posedge tmr_rst) begin
        if (tmr_rst) q <= '0;
        else         q <= d;
    end

    assign evt_tog  = q.tog;
    assign tick     = q.tick;
    assign count    = q.count;
    assign wake_req = q.wake;

    assert_no_match_in_blank_R10: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        q.blank_q |=> ((q.tog[F_CMPA] == $past(q.tog[F_CMPA])) &&
                       (q.tog[F_CMPB] == $past(q.tog[F_CMPB]))));

    assert_cnt_load_lands_R5: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        cnt_load |=> (q.count == $past(cnt_val)));
endmodule

// File: rtl/tmr_async_bridge.sv
module tmr_async_bridge
    import tmr_bridge_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              tmr_clk,
    input  logic              tmr_rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic [FLAG_N-1:0] irq_flags,
    output logic              wake_req
);
    localparam int NREG  = REG_N;
    localparam int NFLAG = FLAG_N;

    logic [NREG-1:0] wr_stb;
    logic [NREG-1:0] busy;
    logic [NREG-1:0] load;
    logic [DW-1:0]   stage [NREG];
    logic [DW-1:0]   dest  [NREG];
    logic [NFLAG-1:0] evt_tog;
    logic            tick;
    logic [DW-1:0]   tmr_count;

    typedef struct packed {
        logic          tick_m;
        logic          tick_s;
        logic          tick_p;
        logic [DW-1:0] shadow;
        logic          blank;
    } st_t;

    st_t d, q;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_chan
            assign wr_stb[g] = bus_we && (bus_addr == AW'(g));
            tmr_xfer_chan #(.W(DW)) u_chan (
                .sys_clk   (sys_clk),
                .sys_rst   (sys_rst),
                .wr_stb    (wr_stb[g]),
                .wr_val    (bus_wdata),
                .busy      (busy[g]),
                .stage_val (stage[g]),
                .tmr_clk   (tmr_clk),
                .tmr_rst   (tmr_rst),
                .tmr_load  (load[g]),
                .tmr_val   (dest[g])
            );
        end
    endgenerate

    tmr_count_core #(.W(DW), .NF(NFLAG)) u_core (
        .tmr_clk   (tmr_clk),
        .tmr_rst   (tmr_rst),
        .cnt_load  (load[A_CNT]),
        .cnt_val   (stage[A_CNT]),
        .cmp_a     (dest[A_CMPA]),
        .cmp_b     (dest[A_CMPB]),
        .run       (dest[A_CTL0][RUN_BIT]),
        .wake_mask (dest[A_CTL1][NFLAG-1:0]),
        .blank_src (q.blank),
        .evt_tog   (evt_tog),
        .tick      (tick),
        .count     (tmr_count),
        .wake_req  (wake_req)
    );

    tmr_flag_sync #(.N(NFLAG)) u_flags (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .tog_in  (evt_tog),
        .clr     (flag_clr),
        .flags   (irq_flags)
    );

    // read-back copy refreshed once per timer edge, plus registered blanking source
    always_comb begin
        d        = q;
        d.tick_m = tick;
        d.tick_s = q.tick_m;
        d.tick_p = q.tick_s;
        if (q.tick_s != q.tick_p) begin
            d.shadow = tmr_count;
        end
        d.blank = busy[A_CNT] | busy[A_CMPA] | busy[A_CMPB];
    end

    always_ff @(posedge sys_clk or posedge sys_rst) begin
        if (sys_rst) q <= '0;
        else         q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CNT:  bus_rdata = q.shadow;
            A_CMPA: bus_rdata = stage[A_CMPA];
            A_CMPB: bus_rdata = stage[A_CMPB];
            A_CTL0: bus_rdata = stage[A_CTL0];
            A_CTL1: bus_rdata = stage[A_CTL1];
            A_STAT: bus_rdata = DW'(busy);
            A_FLAG: bus_rdata = DW'(irq_flags);
            default: bus_rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{dest[A_CNT], dest[A_CTL0][DW-1:1],
                           dest[A_CTL1][DW-1:NFLAG], load[NREG-1:1]};

    assert_cnt_visible_R5: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $fell(busy[A_CNT]) |-> (q.shadow == stage[A_CNT]));
endmodule

// File: tb/tmr_async_bridge_tb.sv
`timescale 1ns/1ps
module tmr_async_bridge_tb;
    import tmr_bridge_pkg::*;

    logic       sys_clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       tmr_clk = 1'b0;
    logic       tmr_rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] flag_clr = '0;
    logic [2:0] irq_flags;
    logic       wake_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int     wake_cnt = 0;
    longint wake_rise = 0;
    longint wake_w = 0;

    tmr_async_bridge u_dut (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .tmr_clk   (tmr_clk),
        .tmr_rst   (tmr_rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flag_clr  (flag_clr),
        .irq_flags (irq_flags),
        .wake_req  (wake_req)
    );

    always #4 sys_clk = ~sys_clk;

    initial begin
        int phase;
        phase = $urandom_range(1, 159);
        #(phase);
        forever #80 tmr_clk = ~tmr_clk;
    end

    always @(posedge wake_req) begin
        wake_cnt++;
        wake_rise = $time;
    end
    always @(negedge wake_req) wake_w = $time - wake_rise;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge sys_clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(negedge sys_clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(input int idx, output int cyc);
        logic [7:0] st;
        cyc = 0;
        for (int i = 0; i < 2000; i++) begin
            rd(A_STAT, st);
            if (!st[idx]) break;
            @(negedge sys_clk);
            cyc++;
        end
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        @(negedge sys_clk);
        flag_clr = m;
        @(negedge sys_clk);
        flag_clr = '0;
    endtask

    task automatic wait_flag(input int b, output int cur, output int prev);
        logic [7:0] v;
        prev = -1; cur = -1;
        rd(A_CNT, v);
        for (int i = 0; i < 8000; i++) begin
            @(negedge sys_clk);
            prev = cur;
            rd(A_CNT, v);
            cur = int'(v);
            if (irq_flags[b]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 addr%0d", a), int'(v), 0);
        end
        chk("R1 flags", int'(irq_flags), 0);
        chk("R1 wake", int'(wake_req), 0);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        int cyc;
        wr(A_CMPA, 8'h40);
        rd(A_STAT, v);
        chk("R2 busy set", int'(v[1]), 1);
        wait_idle(1, cyc);
        chk("R2 busy window", int'(cyc >= 40 && cyc <= 66), 1);
        rd(A_CMPA, v);
        chk("R2 value", int'(v), 8'h40);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        int cyc;
        @(negedge sys_clk);
        bus_addr = A_CMPA; bus_we = 1'b1; bus_wdata = 8'h11;
        @(negedge sys_clk);
        bus_wdata = 8'h22;
        @(negedge sys_clk);
        bus_we = 1'b0;
        wait_idle(1, cyc);
        rd(A_CMPA, v);
        chk("R3 dropped write", int'(v), 8'h11);
        repeat (100) @(negedge sys_clk);
        rd(A_STAT, v);
        chk("R3 not queued", int'(v[1]), 0);
    endtask

    task automatic t_indep();
        logic [7:0] v;
        int cyc;
        wr(A_CMPB, 8'h5A);
        wr(A_CTL1, 8'h80);
        rd(A_STAT, v);
        chk("R4 both busy", int'(v & 8'h14), 8'h14);
        wait_idle(2, cyc);
        wait_idle(4, cyc);
        rd(A_CMPB, v);
        chk("R4 cmpb", int'(v), 8'h5A);
        rd(A_CTL1, v);
        chk("R4 ctl1", int'(v), 8'h80);
    endtask

    task automatic t_cnt_load();
        logic [7:0] v;
        int cyc;
        wr(A_CNT, 8'h37);
        wait_idle(0, cyc);
        rd(A_CNT, v);
        chk("R5 count at idle", int'(v), 8'h37);
        repeat (100) @(negedge sys_clk);
        rd(A_CNT, v);
        chk("R6 hold stopped", int'(v), 8'h37);
    endtask

    task automatic t_run();
        logic [7:0] v;
        int cyc, prev, changes, gap, errs;
        wr(A_CTL0, 8'h01);
        wait_idle(3, cyc);
        rd(A_CNT, v);
        prev = int'(v); changes = 0; gap = 0; errs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge sys_clk);
            rd(A_CNT, v);
            gap++;
            if (int'(v) != prev) begin
                if (int'(v) != ((prev + 1) & 255)) errs++;
                if (changes > 0 && gap != 20) errs++;
                changes++;
                gap = 0;
                prev = int'(v);
            end
        end
        chk("R6 step and spacing", errs, 0);
        chk("R6 enough steps", int'(changes >= 12), 1);
    endtask

    task automatic t_overflow();
        int cur, prev;
        pulse_clr(3'b111);
        wait_flag(F_OVF, cur, prev);
        chk("R7 count at flag", cur, 0);
        chk("R7 count before flag", prev, 255);
        chk("R11 masked no wake", wake_cnt, 0);
    endtask

    task automatic t_cmpa_wake();
        logic [7:0] v;
        int cyc, cur, prev, tgt;
        wr(A_CTL1, 8'h01);
        wait_idle(4, cyc);
        rd(A_CNT, v);
        tgt = (int'(v) + 40) & 255;
        wr(A_CMPA, 8'(tgt));
        wait_idle(1, cyc);
        pulse_clr(3'b001);
        wake_cnt = 0;
        wait_flag(F_CMPA, cur, prev);
        chk("R8 A count at flag", cur, (tgt + 1) & 255);
        chk("R8 A count before flag", prev, tgt);
        repeat (30) @(negedge sys_clk);
        chk("R11 wake count", wake_cnt, 1);
        chk("R11 wake width", int'(wake_w), 160);
    endtask

    task automatic t_cmpb_blank();
        logic [7:0] v;
        int cyc, cur, prev, tgt;
        rd(A_CNT, v);
        tgt = (int'(v) + 100) & 255;
        wr(A_CMPB, 8'(tgt));
        wait_idle(2, cyc);
        pulse_clr(3'b010);
        wr(A_CNT, 8'(tgt));
        wait_idle(0, cyc);
        rd(A_CNT, v);
        chk("R5 running count at idle", int'(v), tgt);
        repeat (60) @(negedge sys_clk);
        chk("R10 blanked match", int'(irq_flags[F_CMPB]), 0);
        wait_flag(F_CMPB, cur, prev);
        chk("R8 B count at flag", cur, (tgt + 1) & 255);
        chk("R8 B count before flag", prev, tgt);
    endtask

    task automatic t_w1c();
        chk("R9 pre A", int'(irq_flags[F_CMPA]), 1);
        pulse_clr(3'b010);
        chk("R9 B cleared", int'(irq_flags[F_CMPB]), 0);
        chk("R9 A kept", int'(irq_flags[F_CMPA]), 1);
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500;
        @(negedge sys_clk);
        sys_rst = 1'b0;
        tmr_rst = 1'b0;
        repeat (2) @(negedge sys_clk);
        t_reset();
        t_busy();
        t_ignore();
        t_indep();
        t_cnt_load();
        t_run();
        t_overflow();
        t_cmpa_wake();
        t_cmpb_blank();
        t_w1c();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule